// File: doc/BRIEF.md
# Attenuated Square-Wave Beep Generator

The block makes a fixed-pitch audible tone from a fast system clock, for a small class-D audio amplifier. A free-running binary counter advances on every clock edge. Its top bit is the raw tone, a square wave whose period is 2^CNT_W clock cycles. With the default 18-bit counter and a 100 MHz clock, the tone sits near 381 Hz.

A 50% square wave is very loud on a small speaker. The default output is therefore attenuated. The speaker pin is driven only while the tone is high and the low GATE_BITS bits of the counter are all zero. During the tone's high half this gives one single-cycle pulse in every 2^GATE_BITS cycles, which is 1/64 of the time with the default of 6 bits. A volume-mode input selects full volume instead, and the raw tone then goes straight to the pin.

The amplifier's shutdown pin is passed straight through from a user switch; the amplifier plays only while that pin is high. Three debug lines mirror the raw tone, the speaker drive and the enable switch so they can be shown on LEDs.

Top module: `beep_gen`

## Requirements
- R1: While rst_ni is low the counter is held at zero, so tone_dbg_o and spk_o are 0. After release the counter counts up from zero.
- R2: The counter advances by one on every rising clock edge and wraps from all ones to zero. At the k-th sample after reset release the counter holds k mod 2^CNT_W.
- R3: With full_vol_i = 0, spk_o is 1 exactly when the counter's top bit is 1 and its low GATE_BITS bits are all 0. spk_o is never 1 while the tone is low.
- R4: With full_vol_i = 1, spk_o equals the counter's top bit, a 50% duty square wave.
- R5: amp_en_o follows amp_en_i in the same cycle, with no register between them. Level 1 enables the amplifier.
- R6: tone_dbg_o shows the raw tone (the counter's top bit), spk_dbg_o equals spk_o, and en_dbg_o equals amp_en_i.
- R7: With full_vol_i = 0, each high half of the tone carries exactly 2^(CNT_W-1-GATE_BITS) pulses on spk_o. Each pulse is one cycle wide, and the pulses are spaced 2^GATE_BITS cycles apart.
- R8: tone_dbg_o rises once every 2^CNT_W cycles. Changing full_vol_i or amp_en_i has no effect on the tone timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| amp_en_i | input | 1 | Amplifier enable switch |
| full_vol_i | input | 1 | 1 = raw square wave, 0 = attenuated pulses |
| spk_o | output | 1 | Speaker drive to amplifier input |
| amp_en_o | output | 1 | Amplifier shutdown pin, high = play |
| tone_dbg_o | output | 1 | Debug: raw tone |
| spk_dbg_o | output | 1 | Debug: speaker drive |
| en_dbg_o | output | 1 | Debug: enable switch state |

## Verification
The counter is the only register in the block, and every output is a combinational function of it and the two inputs. A change on amp_en_i or full_vol_i therefore shows up on the pins in the same cycle. A counter step shows up one cycle after the edge that makes it. The bench releases reset at a falling edge and numbers each following falling edge k, at which point the counter must hold k. For each k the driver task queues the expected pin values, computed from k and the inputs it applies in that cycle. The monitor samples 1 ns after the same falling edge, well clear of the rising edge, and compares. Pulse counts per tone half and the spacing of tone rises are gathered from the same samples.

// File: rtl/beep_pkg.sv
package beep_pkg;
  localparam int unsigned DEF_CNT_W     = 18;
  localparam int unsigned DEF_GATE_BITS = 6;
endpackage

// File: rtl/beep_counter.sv
module beep_counter #(
  parameter int unsigned CNT_W = beep_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tone_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign tone_o = cnt_q[CNT_W-1];

  // R2: wrap from all ones back to zero
  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == {CNT_W{1'b1}}) |=> (cnt_q == '0));

  // R8: the tone rises only when the rest of the counter is clear
  p_tone_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tone_o) |-> (cnt_q[CNT_W-2:0] == '0));
endmodule

// File: rtl/beep_gate.sv
module beep_gate #(
  parameter int unsigned CNT_W     = beep_pkg::DEF_CNT_W,
  parameter int unsigned GATE_BITS = beep_pkg::DEF_GATE_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tone_i,
  input  logic             full_vol_i,
  output logic             spk_o
);
  logic qual;

  generate
    if (GATE_BITS == 0) begin : g_no_gate
      assign qual = 1'b1;
    end else begin : g_gate
      assign qual = (cnt_i[GATE_BITS-1:0] == '0);
    end
  endgenerate

  assign spk_o = full_vol_i ? tone_i : (tone_i & qual);

  // R3: no drive while the tone is low
  p_quiet_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tone_i |-> !spk_o);

  // R4: full volume passes the tone
  p_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_vol_i |-> (spk_o == tone_i));

  // R7: attenuated pulses last one cycle
  if (GATE_BITS > 0) begin : g_width_chk
    p_pulse_width_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (spk_o && !full_vol_i) |=> (!spk_o || full_vol_i));
  end
endmodule

// File: rtl/beep_gen.sv
module beep_gen #(
  parameter int unsigned CNT_W     = beep_pkg::DEF_CNT_W,
  parameter int unsigned GATE_BITS = beep_pkg::DEF_GATE_BITS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic amp_en_i,
  input  logic full_vol_i,
  output logic spk_o,
  output logic amp_en_o,
  output logic tone_dbg_o,
  output logic spk_dbg_o,
  output logic en_dbg_o
);
  logic [CNT_W-1:0] cnt;
  logic             tone;
  logic             spk;

  beep_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt),
    .tone_o (tone)
  );

  beep_gate #(.CNT_W(CNT_W), .GATE_BITS(GATE_BITS)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt),
    .tone_i     (tone),
    .full_vol_i (full_vol_i),
    .spk_o      (spk)
  );

  assign spk_o      = spk;
  assign amp_en_o   = amp_en_i;
  assign tone_dbg_o = tone;
  assign spk_dbg_o  = spk;
  assign en_dbg_o   = amp_en_i;

  // R6: debug copy of speaker drive agrees with the pin
  p_dbg_spk_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spk_dbg_o == spk_o);
endmodule

// File: tb/beep_gen_tb.sv
module beep_gen_tb;
  localparam int W  = 10;
  localparam int G  = 6;
  localparam int P  = 1 << W;
  localparam int HP = P / 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic amp_en_i = 1'b0;
  logic full_vol_i = 1'b0;
  logic spk_o, amp_en_o, tone_dbg_o, spk_dbg_o, en_dbg_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed { int k; logic full; logic en; } item_t;
  item_t q[$];
  int k_next = 0;

  int hi_pulses = 0, lo_pulses = 0;
  int last_rise = -1, rise_seen = 0;
  logic prev_tone = 1'b0;

  always #2 clk_i = ~clk_i;

  beep_gen #(.CNT_W(W), .GATE_BITS(G)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .amp_en_i(amp_en_i), .full_vol_i(full_vol_i),
    .spk_o(spk_o), .amp_en_o(amp_en_o), .tone_dbg_o(tone_dbg_o),
    .spk_dbg_o(spk_dbg_o), .en_dbg_o(en_dbg_o)
  );

  task automatic chk(input string req, input logic act, input logic exp, input int k);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s k=%0d actual=%b expected=%b", req, k, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: apply inputs at a falling edge, queue expectations
  task automatic drive(input logic full, input logic en, input int n);
    for (int i = 0; i < n; i++) begin
      item_t it;
      full_vol_i = full;
      amp_en_i   = en;
      it.k = k_next; it.full = full; it.en = en;
      q.push_back(it);
      k_next++;
      @(negedge clk_i);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      int c;
      logic et, es;
      it = q.pop_front();
      c  = it.k % P;
      et = (c >= HP);
      es = it.full ? et : (et && (c % (1 << G)) == 0);
      chk("R2/R8 tone", tone_dbg_o, et, it.k);
      chk(it.full ? "R4 full spk" : "R3 gated spk", spk_o, es, it.k);
      chk("R5 amp_en", amp_en_o, it.en, it.k);
      chk("R6 dbg_spk", spk_dbg_o, es, it.k);
      chk("R6 dbg_en", en_dbg_o, it.en, it.k);
      if (!it.full && it.k < P) begin
        if (spk_o && c >= HP) hi_pulses++;
        if (spk_o && c <  HP) lo_pulses++;
      end
      if (tone_dbg_o && !prev_tone) begin
        if (last_rise >= 0) begin
          chk_int("R8 tone period", it.k - last_rise, P);
          rise_seen++;
        end
        last_rise = it.k;
      end
      prev_tone = tone_dbg_o;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 reset tone", tone_dbg_o, 1'b0, -1);
    chk("R1 reset spk", spk_o, 1'b0, -1);
    full_vol_i = 1'b1;
    #1;
    chk("R1 reset spk full", spk_o, 1'b0, -1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(1'b0, 1'b1, P);          // attenuated, first full period
    drive(1'b0, 1'b0, P);          // attenuated, amp off
    drive(1'b1, 1'b1, P);          // full volume
    for (int j = 0; j < 64; j++)   // toggle modes every few cycles
      drive(j[0], j[1], 17);
    drive(1'b0, 1'b1, P);
    @(negedge clk_i); #2;
    chk_int("R7 pulses in high half", hi_pulses, HP >> G);
    chk_int("R3 pulses in low half", lo_pulses, 0);
    checks++;
    if (rise_seen < 3) begin
      fails++;
      $display("FAIL R8 tone rises actual=%0d expected>=3", rise_seen);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule